// File: doc/BRIEF.md
# UART Register Control Core

This block is the register-facing half of a serial port. A host reaches it through a small byte-wide register bus: two mode bytes sharing one address through a pointer that advances on access, a status byte, a command byte, a transmit holding byte, a four-deep receive queue and an interrupt status and mask pair. On its far side it talks to an external serializer through byte-level handshakes. It accepts received bytes and break events, and it hands transmit bytes out one at a time.

The command byte holds three independent fields: a miscellaneous action, a transmitter action and a receiver action. All three apply in the same write. The receive interrupt source is chosen by one mode bit: either "data present" or "queue full". A line break places a zero byte into the receive queue. If the queue is already full, that zero replaces the newest entry.

Top module: `uart_ctl_core`

## Requirements
- R1: After reset the status byte (address 0x04) reads 0x08, with only the transmitter-empty bit (bit 3) set. Status bits 7..4 always read 0. `irq` is low and `rx_ready` is low because the receiver starts disabled.
- R2: Reading or writing address 0x00 reaches mode byte 1 after reset or after a pointer-reset command, and reaches mode byte 2 from then on. Command field [6:4] = 1 returns the pointer to mode byte 1.
- R3: A command write (address 0x08) decodes bits [3:2] as the transmitter action and bits [1:0] as the receiver action: 1 enables, 2 disables, 0 and 3 leave the state unchanged. Bits [6:4] are decoded independently in the same write.
- R4: `rx_ready` is high exactly while the receiver is enabled and the queue holds fewer than 4 bytes. A byte is taken into the queue in a cycle where `rx_valid` and `rx_ready` are both high.
- R5: A stored byte sets status bit 0. Reaching 4 stored bytes sets status bit 1. A read of address 0x0C returns the oldest byte and removes it, which clears bit 1, and clears bit 0 once the queue is empty. A read of an empty queue returns 0 and changes nothing.
- R6: Command field [6:4] = 2 empties the receive queue and clears status bits 0 and 1.
- R7: A write to address 0x0C clears status bits 3 and 2. With the transmitter enabled, the next cycle raises `tx_valid` for one cycle with that byte on `tx_data`, and status bits 3 and 2 then read 1.
- R8: While the transmitter is disabled, status bit 2 stays low and a written byte is held without a handoff. Enabling the transmitter later releases that byte. The disable command clears bit 2.
- R9: Command field [6:4] = 3 sets status bit 3, clears bit 2, and discards any held transmit byte.
- R10: A `brk_evt` pulse sets interrupt status bit 2 and stores a zero byte, whether or not the receiver is enabled. If the queue is full, the zero overwrites the newest entry. A `rx_valid` byte in the same cycle is dropped.
- R11: Command field [6:4] = 5 clears interrupt status bit 2.
- R12: Interrupt status (read at 0x14) has bit 0 equal to status bit 2. Bit 1 equals status bit 1 when mode byte 1 bit 6 is set, and status bit 0 otherwise. Bit 2 is the break flag, and the other bits read 0. `irq` is high when the interrupt status ANDed with the mask (written at 0x14) is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has side effects on 0x00 and 0x0C) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, combinational |
| rx_valid | input | 1 | Serializer offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Core accepts a received byte this cycle |
| brk_evt | input | 1 | One-cycle pulse when a line break is detected |
| tx_valid | output | 1 | One-cycle handoff of a transmit byte |
| tx_data | output | 8 | Transmit byte being handed off |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a break that arrives while the receive queue is full. The bench gets there by enabling the receiver, filling all four entries through the handshake, and confirming that `rx_ready` has dropped. It then pulses `brk_evt` and expects the fourth entry to read back as zero. A second hard case is a break that coincides with an offered byte. The bench drives both in one cycle and expects exactly one zero entry. A transmit byte held by a disabled transmitter and then discarded by a transmitter reset is also covered: a monitor flags any handoff that no byte in its queue of expected bytes accounts for.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;

    // register byte addresses
    localparam int unsigned ADR_MODE = 'h00;
    localparam int unsigned ADR_STAT = 'h04;
    localparam int unsigned ADR_CMD  = 'h08;
    localparam int unsigned ADR_DATA = 'h0C;
    localparam int unsigned ADR_IRQ  = 'h14;

    // miscellaneous command codes, field [6:4]
    localparam logic [2:0] MISC_PTR_RST = 3'd1;
    localparam logic [2:0] MISC_RX_RST  = 3'd2;
    localparam logic [2:0] MISC_TX_RST  = 3'd3;
    localparam logic [2:0] MISC_BRK_CLR = 3'd5;

    // enable field codes for [3:2] and [1:0]
    localparam logic [1:0] EN_ON  = 2'd1;
    localparam logic [1:0] EN_OFF = 2'd2;

    // mode byte 1 bit that selects the receive interrupt source
    localparam int unsigned MODE1_RXSEL_BIT = 6;

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
    } cmd_act_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
    import uart_ctl_pkg::*;
(
    input  logic       cmd_wr,
    input  logic [7:0] cmd_byte,
    output cmd_act_t   act
);
    logic [2:0] misc_f;
    logic [1:0] tx_f;
    logic [1:0] rx_f;

    assign misc_f = cmd_byte[6:4];
    assign tx_f   = cmd_byte[3:2];
    assign rx_f   = cmd_byte[1:0];

    always_comb begin
        act         = '0;
        act.ptr_rst = cmd_wr && (misc_f == MISC_PTR_RST);
        act.rx_rst  = cmd_wr && (misc_f == MISC_RX_RST);
        act.tx_rst  = cmd_wr && (misc_f == MISC_TX_RST);
        act.brk_clr = cmd_wr && (misc_f == MISC_BRK_CLR);
        act.tx_on   = cmd_wr && (tx_f == EN_ON);
        act.tx_off  = cmd_wr && (tx_f == EN_OFF);
        act.rx_on   = cmd_wr && (rx_f == EN_ON);
        act.rx_off  = cmd_wr && (rx_f == EN_OFF);
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned WIDTH  = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             pop,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             brk_push,
    output logic [WIDTH-1:0] head,
    output logic             nonempty,
    output logic             full
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] ent;
        logic [CNT_W-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t q, d;

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    always_comb begin
        logic [CNT_W-1:0] c;
        d = q;
        c = q.cnt;
        if (flush) begin
            d.cnt = '0;
        end else begin
            if (pop && (c != '0)) begin
                for (int i = 0; i < int'(DEPTH) - 1; i++) begin
                    d.ent[i] = q.ent[i+1];
                end
                c = c - 1'b1;
            end
            if (brk_push) begin
                if (c == FULL_CNT) begin
                    d.ent[DEPTH-1] = '0;
                end else begin
                    for (int i = 0; i < int'(DEPTH); i++) begin
                        if (CNT_W'(i) == c) d.ent[i] = '0;
                    end
                    c = c + 1'b1;
                end
            end else if (push && (c != FULL_CNT)) begin
                for (int i = 0; i < int'(DEPTH); i++) begin
                    if (CNT_W'(i) == c) d.ent[i] = push_data;
                end
                c = c + 1'b1;
            end
            d.cnt = c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head     = q.ent[0];
    assign nonempty = (q.cnt != '0);
    assign full     = (q.cnt == FULL_CNT);

endmodule

// File: rtl/uart_ctl_core.sv
module uart_ctl_core
    import uart_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 5,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    input  logic              brk_evt,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADR_MODE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(ADR_CMD);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(ADR_DATA);
    localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(ADR_IRQ);

    typedef struct packed {
        logic [7:0] mode1;
        logic [7:0] mode2;
        logic       mode_sel;
        logic       tx_en;
        logic       rx_en;
        logic       tx_empty;
        logic       tx_rdy;
        logic [7:0] tx_hold;
        logic       brk_flag;
        logic [7:0] mask;
    } core_st_t;

    core_st_t q, d;
    cmd_act_t act;

    logic [7:0] fifo_head;
    logic       fifo_nonempty;
    logic       fifo_full;
    logic       fifo_pop;
    logic       fifo_push;
    logic [7:0] status_w;
    logic [7:0] isr_w;
    logic       rx_src;

    uart_cmd_decode u_dec (
        .cmd_wr   (reg_wr && (reg_addr == A_CMD)),
        .cmd_byte (reg_wdata),
        .act      (act)
    );

    assign rx_ready  = q.rx_en && !fifo_full;
    assign fifo_push = rx_valid && rx_ready;
    assign fifo_pop  = reg_rd && (reg_addr == A_DATA);

    uart_rx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (8)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (act.rx_rst),
        .pop       (fifo_pop),
        .push      (fifo_push),
        .push_data (rx_data),
        .brk_push  (brk_evt),
        .head      (fifo_head),
        .nonempty  (fifo_nonempty),
        .full      (fifo_full)
    );

    assign tx_valid = q.tx_en && !q.tx_empty;
    assign tx_data  = q.tx_hold;

    always_comb begin
        d = q;
        // mode bytes and pointer
        if (reg_wr && (reg_addr == A_MODE)) begin
            if (q.mode_sel) d.mode2 = reg_wdata;
            else            d.mode1 = reg_wdata;
        end
        if ((reg_wr || reg_rd) && (reg_addr == A_MODE)) d.mode_sel = 1'b1;
        if (act.ptr_rst) d.mode_sel = 1'b0;

        // transmit path
        if (tx_valid) begin
            d.tx_empty = 1'b1;
            d.tx_rdy   = 1'b1;
        end
        if (reg_wr && (reg_addr == A_DATA)) begin
            d.tx_hold  = reg_wdata;
            d.tx_empty = 1'b0;
            d.tx_rdy   = 1'b0;
        end
        if (act.tx_rst) begin
            d.tx_empty = 1'b1;
            d.tx_rdy   = 1'b0;
        end
        if (act.tx_on) begin
            d.tx_en = 1'b1;
            if (d.tx_empty) d.tx_rdy = 1'b1;
        end
        if (act.tx_off) begin
            d.tx_en  = 1'b0;
            d.tx_rdy = 1'b0;
        end

        // receive enable
        if (act.rx_on)  d.rx_en = 1'b1;
        if (act.rx_off) d.rx_en = 1'b0;

        // break flag: a new break wins over a clear in the same cycle
        if (act.brk_clr) d.brk_flag = 1'b0;
        if (brk_evt)     d.brk_flag = 1'b1;

        if (reg_wr && (reg_addr == A_IRQ)) d.mask = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.tx_empty <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign status_w = {4'b0000, q.tx_empty, q.tx_rdy, fifo_full, fifo_nonempty};
    assign rx_src   = q.mode1[MODE1_RXSEL_BIT] ? fifo_full : fifo_nonempty;
    assign isr_w    = {5'b00000, q.brk_flag, rx_src, q.tx_rdy};
    assign irq      = |(isr_w & q.mask);

    always_comb begin
        unique case (reg_addr)
            A_MODE:  reg_rdata = q.mode_sel ? q.mode2 : q.mode1;
            A_STAT:  reg_rdata = status_w;
            A_DATA:  reg_rdata = fifo_nonempty ? fifo_head : 8'h00;
            A_IRQ:   reg_rdata = isr_w;
            default: reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/uart_ctl_core_chk.sv
module uart_ctl_core_chk #(
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              brk_evt,
    input logic              tx_valid,
    input logic [7:0]        status,
    input logic [7:0]        isr
);
    // R4: a full queue refuses bytes
    a_r4_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] |-> !rx_ready);

    // R5: an accepted byte leaves data present
    a_r5_push_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> status[0]);

    // R6: receiver reset empties the queue
    a_r6_rx_reset_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'('h08) && reg_wdata[6:4] == 3'd2 && !brk_evt)
        |=> (!status[0] && !status[1]));

    // R7: writing the holding byte clears the empty flag
    a_r7_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'('h0C)) |=> !status[3]);

    // R7: a handoff with no competing write sets empty and ready
    a_r7_handoff_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !reg_wr) |=> (status[3] && status[2]));

    // R10: a break raises the break flag
    a_r10_break_flag: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> isr[2]);

    // R12: the transmit interrupt bit mirrors transmitter ready
    a_r12_tx_int_follows: assert property (@(posedge clk) disable iff (!rst_n)
        isr[0] == status[2]);
endmodule

bind uart_ctl_core uart_ctl_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .brk_evt   (brk_evt),
    .tx_valid  (tx_valid),
    .status    (status_w),
    .isr       (isr_w)
);

// File: tb/uart_ctl_core_tb.sv
module uart_ctl_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_ready;
    logic       brk_evt = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    byte unsigned rxq[$];
    byte unsigned txq[$];

    always #4 clk = ~clk;

    uart_ctl_core u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .brk_evt(brk_evt), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic expect_reg(input logic [4:0] a, input logic [7:0] e, input string req);
        logic [7:0] v;
        rd(a, v);
        chk(v == e, req, v, e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic rx_offer(input logic [7:0] b, input bit with_brk);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; brk_evt = with_brk;
        #1;
        if (with_brk) rxq.push_back(8'h00);
        else if (rx_ready) rxq.push_back(b);
        @(posedge clk); #1;
        rx_valid = 1'b0; brk_evt = 1'b0;
    endtask

    task automatic brk_pulse();
        @(negedge clk);
        brk_evt = 1'b1;
        #1;
        if (rxq.size() == 4) rxq[3] = 8'h00;
        else rxq.push_back(8'h00);
        @(posedge clk); #1;
        brk_evt = 1'b0;
    endtask

    task automatic pop_rx(input string req);
        logic [7:0] v;
        logic [7:0] e;
        rd(5'h0C, v);
        e = (rxq.size() != 0) ? rxq.pop_front() : 8'h00;
        chk(v == e, req, v, e);
    endtask

    // transmit monitor: every handoff must match the oldest expected byte
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            if (txq.size() == 0) begin
                chk(1'b0, "R8/R9 unexpected handoff", tx_data, 0);
            end else begin
                byte unsigned e;
                e = txq.pop_front();
                chk(tx_data == e, "R7 handoff data", tx_data, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle(2);
        #2 rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(rx_ready == 1'b0, "R1 rx_ready", rx_ready, 0);
        expect_reg(5'h04, 8'h08, "R1 status");

        // R2 mode pointer
        wr(5'h00, 8'h40);
        wr(5'h00, 8'h13);
        expect_reg(5'h00, 8'h13, "R2 second access hits mode 2");
        wr(5'h08, 8'h10);
        expect_reg(5'h00, 8'h40, "R2 pointer reset to mode 1");
        expect_reg(5'h00, 8'h13, "R2 pointer advanced");
        wr(5'h08, 8'h10);
        wr(5'h00, 8'h00);

        // R3 enable both directions in one write
        wr(5'h08, 8'h05);
        expect_reg(5'h04, 8'h0C, "R3 tx enable sets ready");
        chk(rx_ready == 1'b1, "R3/R4 rx enabled", rx_ready, 1);

        // R7 transmit handoff
        txq.push_back(8'hA5);
        wr(5'h0C, 8'hA5);
        expect_reg(5'h04, 8'h00, "R7 write clears empty and ready");
        expect_reg(5'h04, 8'h0C, "R7 flags after handoff");

        // R8 disabled transmitter holds the byte
        wr(5'h08, 8'h08);
        expect_reg(5'h04, 8'h08, "R8 disable clears ready");
        wr(5'h0C, 8'h3C);
        idle(3);
        expect_reg(5'h04, 8'h00, "R8 byte held");
        txq.push_back(8'h3C);
        wr(5'h08, 8'h04);
        idle(2);
        expect_reg(5'h04, 8'h0C, "R8 release on enable");

        // R9 transmitter reset discards the held byte
        wr(5'h08, 8'h08);
        wr(5'h0C, 8'h77);
        wr(5'h08, 8'h30);
        expect_reg(5'h04, 8'h08, "R9 tx reset flags");
        wr(5'h08, 8'h04);
        idle(3);
        expect_reg(5'h04, 8'h0C, "R9 nothing left to send");

        // R3 reserved codes ignored
        wr(5'h08, 8'h0F);
        expect_reg(5'h04, 8'h0C, "R3 reserved tx code");
        chk(rx_ready == 1'b1, "R3 reserved rx code", rx_ready, 1);

        // R4/R5 queue fill and drain
        rx_offer(8'h11, 1'b0);
        rx_offer(8'h22, 1'b0);
        rx_offer(8'h33, 1'b0);
        expect_reg(5'h04, 8'h0D, "R5 data present");
        rx_offer(8'h44, 1'b0);
        expect_reg(5'h04, 8'h0F, "R5 queue full");
        chk(rx_ready == 1'b0, "R4 full refuses", rx_ready, 0);
        rx_offer(8'h55, 1'b0);
        pop_rx("R5 oldest first");
        expect_reg(5'h04, 8'h0D, "R5 pop clears full");
        pop_rx("R5 order");
        pop_rx("R5 order");
        pop_rx("R4 refused byte absent");
        expect_reg(5'h04, 8'h0C, "R5 empty clears ready");
        pop_rx("R5 empty read returns zero");

        // R10 break into a full queue
        rx_offer(8'hA1, 1'b0);
        rx_offer(8'hA2, 1'b0);
        rx_offer(8'hA3, 1'b0);
        rx_offer(8'hA4, 1'b0);
        brk_pulse();
        expect_reg(5'h14, 8'h07, "R10/R12 isr with break");
        wr(5'h14, 8'h04);
        chk(irq == 1'b1, "R12 masked break raises irq", irq, 1);
        wr(5'h08, 8'h50);
        expect_reg(5'h14, 8'h03, "R11 break flag cleared");
        chk(irq == 1'b0, "R11 irq drops", irq, 0);
        wr(5'h14, 8'h02);
        chk(irq == 1'b1, "R12 rx interrupt", irq, 1);
        pop_rx("R10 queue kept");
        pop_rx("R10 queue kept");
        pop_rx("R10 queue kept");
        pop_rx("R10 newest overwritten by zero");
        expect_reg(5'h14, 8'h01, "R12 rx source idle");
        chk(irq == 1'b0, "R12 irq low", irq, 0);

        // R12 full-select source and R6 receiver reset
        wr(5'h08, 8'h10);
        wr(5'h00, 8'h40);
        rx_offer(8'h01, 1'b0);
        expect_reg(5'h14, 8'h01, "R12 full-select not full");
        rx_offer(8'h02, 1'b0);
        rx_offer(8'h03, 1'b0);
        rx_offer(8'h04, 1'b0);
        expect_reg(5'h14, 8'h03, "R12 full-select full");
        chk(irq == 1'b1, "R12 irq on full", irq, 1);
        wr(5'h08, 8'h20);
        rxq.delete();
        expect_reg(5'h04, 8'h0C, "R6 receiver reset");
        pop_rx("R6 queue empty");

        // R10 break and byte in the same cycle
        rx_offer(8'h99, 1'b1);
        expect_reg(5'h04, 8'h0D, "R10 single entry");
        pop_rx("R10 break byte only");
        expect_reg(5'h04, 8'h0C, "R10 nothing else stored");

        idle(2);
        chk(txq.size() == 0, "R7 all handoffs seen", txq.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule